// File: doc/BRIEF.md
# Cartridge Halfword Prefetch Buffer

This block fetches 16-bit halfwords from cartridge ROM ahead of demand while the processor is busy elsewhere, and holds them in a small circular store until a consumer pops them. A restart request gives it a starting address. From there it walks forward two bytes at a time. Before each fetch it waits out a programmable latency, which models the cartridge access time: a non-sequential wait applies to the first fetch after a restart, and a sequential wait applies to each fetch after that.

Each slot of the store is selected directly by the address bits of the halfword it holds, so there is no separate write pointer. An occupancy counter tracks how many halfwords are held. Fetching pauses while the store is full, while prefetch is disabled, or while the stop input is set. A cartridge access that does not use the prefetcher raises the flush input, which empties the store and halts fetching until the next restart. A consumer can pop one halfword, or a 32-bit word made of two consecutive halfwords. A pop that asks for more halfwords than are held is stalled.

Top module: `cart_pf_buffer`

## Requirements
- R1: After reset, fill_level is 0, rom_req stays low, and every pop is stalled until the first sync_req.
- R2: A sync_req (without flush) empties the store. It sets both the fetch and pop addresses to sync_addr with bit 0 cleared. The first fetch occurs on the Nth rising edge after the capturing edge, where N is nseq_wait; a value of 0 behaves as 1.
- R3: Each fetch reads rom_data in the cycle rom_req is high. It then advances rom_addr by 2, and the next fetch follows seq_wait active edges later (0 behaves as 1).
- R4: Halfwords are stored in the slot selected by address bits [3:1] and are popped in address order. This holds across slot wrap-around and across wrap of the address space.
- R5: When fill_level equals DEPTH (8), full is high, no fetch occurs, and the wait countdown holds its value.
- R6: While pf_enable is low or pf_stop is high, no fetch occurs and the wait countdown holds its value.
- R7: A halfword pop returns the halfword in pop_data[15:0] with bits [31:16] zero. A word pop (pop_word=1) returns the halfword at the lower address in [15:0] and the next halfword in [31:16].
- R8: A pop needs at least 1 (halfword) or 2 (word) held entries. Otherwise pop_ack is low, pop_stall is high, and nothing is removed.
- R9: flush empties the store and stops fetching until the next sync_req. flush takes precedence over a simultaneous sync_req. A pop in a cycle with flush or sync_req is stalled.
- R10: When a fetch and a pop happen in the same cycle, fill_level changes by one minus the number of halfwords popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf_enable | input | 1 | Prefetch enable |
| pf_stop | input | 1 | Stop flag, pauses fetching |
| seq_wait | input | WAIT_W | Wait for sequential fetches |
| nseq_wait | input | WAIT_W | Wait for the first fetch after a restart |
| sync_req | input | 1 | Restart at sync_addr |
| sync_addr | input | ADDR_W | Restart byte address |
| flush | input | 1 | Bypassing cartridge access: empty and halt |
| rom_req | output | 1 | Fetch strobe this cycle |
| rom_addr | output | ADDR_W | Fetch byte address |
| rom_data | input | 16 | Halfword returned for rom_addr in the same cycle |
| pop_req | input | 1 | Pop request |
| pop_word | input | 1 | 1: pop two halfwords, 0: pop one |
| pop_ack | output | 1 | Pop accepted this cycle |
| pop_stall | output | 1 | Pop requested but not accepted |
| pop_data | output | 32 | Popped data |
| fill_level | output | CNT_W | Held halfwords |
| full | output | 1 | Store holds DEPTH halfwords |

## Verification
The bench builds the block with its defaults: DEPTH 8, a 4-bit wait field and a 25-bit address. These values make the full limit, wrap-around in slot index, and every wait value from 0 to 15 reachable within a few cycles each. The default address width also lets a restart placed just below the top of the address space show the fetch address wrapping to zero. Random restarts, flushes, pauses and mixed-size pops are compared cycle by cycle against a bench model, and directed runs cover fill-to-full, zero waits and a flush that coincides with a restart.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
   localparam int HALF_W = 16;

   function automatic logic [1:0] pop_need(input logic word);
      return word ? 2'd2 : 2'd1;
   endfunction
endpackage

// File: rtl/pf_wait_timer.sv
module pf_wait_timer #(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_nseq,
   input  logic              run,
   input  logic [WAIT_W-1:0] nseq_wait,
   input  logic [WAIT_W-1:0] seq_wait,
   output logic              fire
);
   logic [WAIT_W-1:0] cd_q;
   logic              due;

   assign due  = (cd_q <= WAIT_W'(1));
   assign fire = run && due;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cd_q <= '0;
      else if (load_nseq) cd_q <= nseq_wait;
      else if (run)       cd_q <= due ? seq_wait : cd_q - WAIT_W'(1);
   end
endmodule

// File: rtl/pf_occupancy.sv
module pf_occupancy #(
   parameter int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   input  logic [1:0]       dec,
   output logic [CNT_W-1:0] count,
   output logic             full
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else            cnt_q <= cnt_q + CNT_W'(inc) - CNT_W'(dec);
   end

   assign count = cnt_q;
   assign full  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/pf_slot_store.sv
module pf_slot_store #(
   parameter int DEPTH = 8,
   parameter int DW    = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DW-1:0]    wr_data,
   input  logic [IDX_W-1:0] rd_idx_a,
   input  logic [IDX_W-1:0] rd_idx_b,
   output logic [DW-1:0]    rd_data_a,
   output logic [DW-1:0]    rd_data_b
);
   logic [DW-1:0] slot_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               slot_q[s] <= '0;
         else if (wr_en && wr_idx == IDX_W'(s))    slot_q[s] <= wr_data;
      end
   end

   assign rd_data_a = slot_q[rd_idx_a];
   assign rd_data_b = slot_q[rd_idx_b];
endmodule

// File: rtl/cart_pf_buffer.sv
module cart_pf_buffer
   import cpf_pkg::*;
#(
   parameter int ADDR_W = 25,
   parameter int DEPTH  = 8,
   parameter int WAIT_W = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pf_enable,
   input  logic              pf_stop,
   input  logic [WAIT_W-1:0] seq_wait,
   input  logic [WAIT_W-1:0] nseq_wait,
   input  logic              sync_req,
   input  logic [ADDR_W-1:0] sync_addr,
   input  logic              flush,
   output logic              rom_req,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [15:0]       rom_data,
   input  logic              pop_req,
   input  logic              pop_word,
   output logic              pop_ack,
   output logic              pop_stall,
   output logic [31:0]       pop_data,
   output logic [CNT_W-1:0]  fill_level,
   output logic              full
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cart_pf_buffer: DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W + 2) begin : g_bad_addr
      $error("cart_pf_buffer: ADDR_W too small for DEPTH");
   end
   if (WAIT_W < 1) begin : g_bad_wait
      $error("cart_pf_buffer: WAIT_W must be at least 1");
   end

   logic              armed_q;
   logic [ADDR_W-1:0] ld_addr_q, rd_addr_q;
   logic              clear, restart, run, fire;
   logic [1:0]        need, dec;
   logic [HALF_W-1:0] lo_half, hi_half;
   logic [ADDR_W-1:0] sync_aligned;

   assign restart      = sync_req && !flush;
   assign clear        = flush || sync_req;
   assign sync_aligned = {sync_addr[ADDR_W-1:1], 1'b0};

   assign run     = armed_q && pf_enable && !pf_stop && !full && !clear;
   assign rom_req = fire;
   assign rom_addr = ld_addr_q;

   assign need      = pop_need(pop_word);
   assign pop_ack   = pop_req && !clear && (fill_level >= CNT_W'(need));
   assign pop_stall = pop_req && !pop_ack;
   assign dec       = pop_ack ? need : 2'd0;
   assign pop_data  = {pop_word ? hi_half : {HALF_W{1'b0}}, lo_half};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         ld_addr_q <= '0;
         rd_addr_q <= '0;
      end else if (flush) begin
         armed_q   <= 1'b0;
      end else if (sync_req) begin
         armed_q   <= 1'b1;
         ld_addr_q <= sync_aligned;
         rd_addr_q <= sync_aligned;
      end else begin
         if (fire)    ld_addr_q <= ld_addr_q + ADDR_W'(2);
         if (pop_ack) rd_addr_q <= rd_addr_q + ADDR_W'({need, 1'b0});
      end
   end

   pf_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_nseq (restart),
      .run       (run),
      .nseq_wait (nseq_wait),
      .seq_wait  (seq_wait),
      .fire      (fire)
   );

   pf_occupancy #(.DEPTH(DEPTH)) u_occ (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .inc   (fire),
      .dec   (dec),
      .count (fill_level),
      .full  (full)
   );

   pf_slot_store #(.DEPTH(DEPTH), .DW(HALF_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (fire),
      .wr_idx    (ld_addr_q[IDX_W:1]),
      .wr_data   (rom_data),
      .rd_idx_a  (rd_addr_q[IDX_W:1]),
      .rd_idx_b  (rd_addr_q[IDX_W:1] + IDX_W'(1)),
      .rd_data_a (lo_half),
      .rd_data_b (hi_half)
   );
endmodule

// File: rtl/pf_buffer_checks.sv
module pf_buffer_checks #(
   parameter int ADDR_W = 25,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pf_enable,
   input logic              pf_stop,
   input logic              sync_req,
   input logic [ADDR_W-1:0] sync_addr,
   input logic              flush,
   input logic              rom_req,
   input logic [ADDR_W-1:0] rom_addr,
   input logic              pop_req,
   input logic              pop_word,
   input logic              pop_ack,
   input logic [CNT_W-1:0]  fill_level
);
   logic [ADDR_W-1:0] exp_next_q;
   logic              seen_sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_next_q  <= '0;
         seen_sync_q <= 1'b0;
      end else if (flush) begin
         seen_sync_q <= seen_sync_q;
      end else if (sync_req) begin
         exp_next_q  <= {sync_addr[ADDR_W-1:1], 1'b0};
         seen_sync_q <= 1'b1;
      end else if (rom_req) begin
         exp_next_q  <= rom_addr + ADDR_W'(2);
      end
   end

   p_idle_until_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_sync_q |-> (!rom_req && !pop_ack));

   p_sync_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |=> (fill_level == '0));

   p_fetch_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req |-> (rom_addr == exp_next_q));

   p_full_no_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level == CNT_W'(DEPTH)) |-> !rom_req);

   p_paused_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pf_enable || pf_stop) |-> !rom_req);

   p_short_pop_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && (fill_level < (pop_word ? CNT_W'(2) : CNT_W'(1)))) |-> !pop_ack);

   p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fill_level == '0));

   p_flush_blocks_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush || sync_req) |-> !pop_ack);

   p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= CNT_W'(DEPTH));
endmodule

bind cart_pf_buffer pf_buffer_checks #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .pf_enable  (pf_enable),
   .pf_stop    (pf_stop),
   .sync_req   (sync_req),
   .sync_addr  (sync_addr),
   .flush      (flush),
   .rom_req    (rom_req),
   .rom_addr   (rom_addr),
   .pop_req    (pop_req),
   .pop_word   (pop_word),
   .pop_ack    (pop_ack),
   .fill_level (fill_level)
);

// File: tb/tb_cart_pf_buffer.sv
`timescale 1ns/1ps
module tb_cart_pf_buffer;
   localparam int AW = 25;
   localparam int DEPTH = 8;
   localparam int WW = 4;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pf_enable = 1'b0, pf_stop = 1'b0;
   logic [WW-1:0] seq_wait = '0, nseq_wait = '0;
   logic sync_req = 1'b0, flush = 1'b0;
   logic [AW-1:0] sync_addr = '0;
   logic rom_req;
   logic [AW-1:0] rom_addr;
   logic [15:0] rom_data;
   logic pop_req = 1'b0, pop_word = 1'b0;
   logic pop_ack, pop_stall, full;
   logic [31:0] pop_data;
   logic [CW-1:0] fill_level;

   int n_checks = 0, n_err = 0;
   bit finished = 0;

   // bench model state
   bit m_armed;
   int m_count, m_cd;
   logic [AW-1:0] m_ld, m_rd;

   always #2.5 clk = ~clk;

   function automatic logic [15:0] rom_fn(input logic [AW-1:0] a);
      return a[16:1] ^ {a[24:17], a[24:17]} ^ 16'h5A3C;
   endfunction

   assign rom_data = rom_fn(rom_addr);

   cart_pf_buffer #(.ADDR_W(AW), .DEPTH(DEPTH), .WAIT_W(WW)) dut (
      .clk(clk), .rst_n(rst_n), .pf_enable(pf_enable), .pf_stop(pf_stop),
      .seq_wait(seq_wait), .nseq_wait(nseq_wait), .sync_req(sync_req),
      .sync_addr(sync_addr), .flush(flush), .rom_req(rom_req), .rom_addr(rom_addr),
      .rom_data(rom_data), .pop_req(pop_req), .pop_word(pop_word), .pop_ack(pop_ack),
      .pop_stall(pop_stall), .pop_data(pop_data), .fill_level(fill_level), .full(full));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // called just after a falling edge with inputs set; checks, advances model, waits
   task automatic cycle(input string tag);
      bit clr, run, fire, ack;
      int need;
      logic [31:0] exp_data;
      #1;
      clr  = flush || sync_req;
      run  = m_armed && pf_enable && !pf_stop && (m_count < DEPTH) && !clr;
      fire = run && (m_cd <= 1);
      need = pop_word ? 2 : 1;
      ack  = pop_req && !clr && (m_count >= need);
      chk(rom_req == fire, tag, "rom_req", 32'(rom_req), 32'(fire));
      if (fire) chk(rom_addr == m_ld, tag, "rom_addr", 32'(rom_addr), 32'(m_ld));
      chk(fill_level == CW'(m_count), tag, "fill_level", 32'(fill_level), 32'(m_count));
      chk(full == (m_count == DEPTH), tag, "full", 32'(full), 32'(m_count == DEPTH));
      if (pop_req) begin
         chk(pop_ack == ack, tag, "pop_ack", 32'(pop_ack), 32'(ack));
         chk(pop_stall == !ack, tag, "pop_stall", 32'(pop_stall), 32'(!ack));
      end
      if (ack) begin
         exp_data = pop_word ? {rom_fn(m_rd + AW'(2)), rom_fn(m_rd)} : {16'h0, rom_fn(m_rd)};
         chk(pop_data == exp_data, tag, "pop_data", pop_data, exp_data);
      end
      if (flush) begin
         m_armed = 0; m_count = 0;
      end else if (sync_req) begin
         m_armed = 1; m_count = 0;
         m_ld = {sync_addr[AW-1:1], 1'b0}; m_rd = m_ld; m_cd = int'(nseq_wait);
      end else begin
         if (fire) begin m_ld = m_ld + AW'(2); m_cd = int'(seq_wait); end
         else if (run) m_cd = m_cd - 1;
         m_count = m_count + (fire ? 1 : 0) - (ack ? need : 0);
         if (ack) m_rd = m_rd + AW'(2 * need);
      end
      @(negedge clk);
   endtask

   task automatic quiet();
      sync_req = 0; flush = 0; pop_req = 0; pop_word = 0;
   endtask

   task automatic restart(input logic [AW-1:0] a, input int nw, input int sw, input string tag);
      quiet();
      sync_req = 1; sync_addr = a; nseq_wait = WW'(nw); seq_wait = WW'(sw);
      cycle(tag);
      sync_req = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7319));
      m_armed = 0; m_count = 0; m_cd = 0; m_ld = '0; m_rd = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, idle without sync
      #1;
      chk(fill_level == '0, "R1", "fill_level after reset", 32'(fill_level), 0);
      chk(rom_req == 1'b0, "R1", "rom_req after reset", 32'(rom_req), 0);
      @(negedge clk);
      pf_enable = 1; pop_req = 1;
      repeat (5) cycle("R1");
      quiet();

      // R2/R3: restart at odd address, nseq 3, seq 2; fill
      restart(AW'(32'h0100_0013), 3, 2, "R2");
      repeat (2) cycle("R2");
      #1 chk(rom_req == 1'b1 && rom_addr == AW'(32'h0100_0012), "R2", "first fetch at 3rd edge",
             {7'd0, rom_req, rom_addr}, {7'd0, 1'b1, AW'(32'h0100_0012)});
      @(negedge clk);
      // realign: the manual look above did not advance the model, redo via model
      m_ld = m_ld + AW'(2); m_cd = 2; m_count = 1;
      repeat (14) cycle("R3");
      // R5: full, stays full
      repeat (10) cycle("R5");
      #1 chk(fill_level == CW'(DEPTH) && full, "R5", "full at 8", 32'(fill_level), DEPTH);
      @(negedge clk);

      // R7/R4: pops of both sizes
      pop_req = 1; pop_word = 0; repeat (3) cycle("R7");
      pop_word = 1; repeat (3) cycle("R7");
      pop_word = 0; repeat (6) cycle("R4");
      quiet();

      // R6: pause by stop, then by disable
      pf_stop = 1; repeat (12) cycle("R6");
      pf_stop = 0; pf_enable = 0; repeat (12) cycle("R6");
      pf_enable = 1; repeat (6) cycle("R6");

      // R8: word pop with one entry, halfword pop when empty
      restart(AW'(32'h0000_0040), 4, 15, "R8");
      pop_req = 1; pop_word = 1; repeat (8) cycle("R8");
      pop_word = 0; repeat (8) cycle("R8");
      quiet();

      // R2/R10: zero waits, continuous halfword pops with fetches
      restart(AW'(32'h0000_01F8), 0, 0, "R2");
      repeat (3) cycle("R2");
      pop_req = 1; repeat (20) cycle("R10");
      pop_word = 1; repeat (10) cycle("R10");
      quiet();

      // R9: flush with simultaneous sync, then no fetch; pop during flush
      repeat (4) cycle("R9");
      flush = 1; sync_req = 1; sync_addr = AW'(32'h0000_0800); pop_req = 1;
      cycle("R9");
      quiet();
      #1 chk(fill_level == '0, "R9", "empty after flush", 32'(fill_level), 0);
      @(negedge clk);
      repeat (20) cycle("R9");

      // R4: address-space wrap
      restart({AW{1'b1}} - AW'(5), 1, 1, "R4");
      repeat (12) cycle("R4");
      pop_req = 1; pop_word = 1; repeat (6) cycle("R4");
      quiet();

      // random mix
      for (int i = 0; i < 4000; i++) begin
         pf_enable = ($urandom % 8) != 0;
         pf_stop   = ($urandom % 10) == 0;
         sync_req  = ($urandom % 40) == 0;
         flush     = ($urandom % 90) == 0;
         sync_addr = AW'($urandom);
         if (sync_req) begin nseq_wait = WW'($urandom); seq_wait = WW'($urandom); end
         pop_req   = ($urandom % 3) == 0;
         pop_word  = $urandom % 2;
         cycle("R4");
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule